// File: doc/BRIEF.md
# Interrupt Cause Mask Controller

This block gathers single-cycle event pulses from the datapath of a network controller into one sticky cause register. It combines them with a software-programmed enable mask and drives a single level interrupt line. Software reaches the block through a simple register port. From there it can read the causes (which clears them), inject causes by hand, set or clear mask bits, program a minimum spacing between interrupt assertions and load an auto-mask pattern.

The interrupt line is throttled in ticks of 256 ns. A prescaler of `TICK_CYCLES` clock cycles makes one tick. This prescaler normally runs freely and restarts when the line is asserted. If auto-masking is enabled and the cause register records that an interrupt was raised, any access to the cause register clears the mask bits named in the auto-mask register.

Register offsets on `addr_i`:

| Offset | Register |
|--------|----------|
| 0xC0 | cause |
| 0xC4 | throttle |
| 0xC8 | cause set |
| 0xD0 | mask set |
| 0xD8 | mask clear |
| 0xE0 | auto-mask |

Top module: `irq_aggr`

## Requirements
- R1: After reset `irq_o` is 0, and reads of cause, mask, throttle and auto-mask all return 0.
- R2: A high `evt_i[i]` sets cause bit i only for the implemented positions 0-4, 6, 7, 9, 10 and 13-17. All other positions of cause bits 30:0 always read 0. Bit 17 is the highest one.
- R3: A read of 0xC0 returns the cause value, with bit 31 included, and then clears all cause bits. An event that arrives in the same cycle as the read is kept.
- R4: A write to 0xC8 ORs the data into the implemented cause bits. Bit 31 is not affected.
- R5: A write to 0xD0 ORs the data into the mask, and a write to 0xD8 clears the mask bits that are 1 in the data. A read of either offset returns the mask.
- R6: `irq_o` rises one cycle after (cause AND mask) becomes nonzero, provided the throttle allows it. It stays high while that value is nonzero and falls one cycle after it becomes zero.
- R7: Cause bit 31 becomes 1 in the same cycle that `irq_o` rises. It is cleared by a cause read or by a write to 0xC0 with data bit 31 set.
- R8: An access to 0xC0 (read or write) clears the mask bits set in the auto-mask register when `auto_mask_en_i` is 1 and cause bit 31 is 1 at that access. Otherwise the mask is unchanged.
- R9: With throttle value T > 0 and a cause kept pending, `irq_o` rises again exactly T*TICK_CYCLES+1 cycles after its previous rise, and never sooner. With T = 0 there is no wait.
- R10: Offset 0xC4 holds 16 bits, with the upper read bits 0. Offset 0xE0 holds 32 bits. `rdata_o` takes the read value at the clock edge that accepts the read. Reads of 0xC8 or of unmapped offsets return 0.
- R11: A write to 0xC0 clears the cause bits that are 1 in the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event pulses, one per cause position |
| auto_mask_en_i | input | 1 | Enables auto-masking on cause access |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt line |

## Verification
- **Register effects:** An event or register write lands in its register at the edge that samples it. The read data for an access is valid after that same edge.
- **Interrupt line:** `irq_o` follows the pending value one edge later. The bench therefore samples at falling edges and checks the line both one half-cycle after a pulse (still low) and one cycle later (high).
- **Throttle timing:** Spacing is measured with a bench cycle counter from one rising of `irq_o` to the next. It is compared with exactly T*TICK_CYCLES+1.
- **Masking and reads:** Auto-mask and read-clear effects are checked by reading the mask or cause back on the next access. The bench also checks that the line drops one cycle after the mask change.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CAUSE_W = DATA_W - 1;

  localparam logic [15:0] OFF_CAUSE = 16'h00C0;
  localparam logic [15:0] OFF_THROT = 16'h00C4;
  localparam logic [15:0] OFF_CSET  = 16'h00C8;
  localparam logic [15:0] OFF_MSET  = 16'h00D0;
  localparam logic [15:0] OFF_MCLR  = 16'h00D8;
  localparam logic [15:0] OFF_AMASK = 16'h00E0;

  // implemented cause positions: 0-4, 6, 7, 9, 10, 13-17
  localparam logic [CAUSE_W-1:0] CAUSE_IMPL = 31'h0003_E6DF;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_CAUSE, ACC_THROT, ACC_CSET, ACC_MSET, ACC_MCLR, ACC_AMASK
  } acc_e;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int unsigned TICK_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (restart_i || (cnt_q == LAST))  cnt_q <= '0;
    else                                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               set_i,
  input  logic               rd_clr_i,
  input  logic               w1c_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               assert_i,
  output logic [DATA_W-1:0]  cause_o
);
  logic [CAUSE_W-1:0] bits_w;
  logic               flag_q;

  for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
    if ((i < NUM_SRC) && CAUSE_IMPL[i]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= evt_i[i] | (set_i & wdata_i[i]) |
                              (bit_q & ~rd_clr_i & ~(w1c_i & wdata_i[i]));
      end
      assign bits_w[i] = bit_q;
    end else begin : g_rsvd
      assign bits_w[i] = 1'b0;
    end
  end

  // assertion flag: a new assertion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   flag_q <= 1'b0;
    else if (assert_i)                             flag_q <= 1'b1;
    else if (rd_clr_i || (w1c_i && wdata_i[DATA_W-1])) flag_q <= 1'b0;
  end

  assign cause_o = {flag_q, bits_w};
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_aggr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              auto_i,
  input  logic              am_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] amask_o
);
  logic [DATA_W-1:0] mask_q, amask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (set_i)  mask_q <= mask_q | wdata_i;
    else if (clr_i)  mask_q <= mask_q & ~wdata_i;
    else if (auto_i) mask_q <= mask_q & ~amask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      amask_q <= '0;
    else if (am_wr_i) amask_q <= wdata_i;
  end

  assign mask_o  = mask_q;
  assign amask_o = amask_q;
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int unsigned ITR_W       = 16,
  parameter int unsigned TICK_CYCLES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             itr_wr_i,
  input  logic [ITR_W-1:0] itr_wdata_i,
  input  logic             pending_i,
  output logic             irq_o,
  output logic             rise_o,
  output logic [ITR_W-1:0] itr_o
);
  logic [ITR_W-1:0] itr_q, tcnt_q;
  logic             irq_q, tick_w, ok_w;

  irq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(rise_o),
    .tick_o   (tick_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       itr_q <= '0;
    else if (itr_wr_i) itr_q <= itr_wdata_i;
  end

  // ticks since last assertion, saturating; starts saturated so the first one is free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tcnt_q <= '1;
    else if (rise_o)                    tcnt_q <= '0;
    else if (tick_w && (tcnt_q != '1)) tcnt_q <= tcnt_q + 1'b1;
  end

  assign ok_w   = (itr_q == '0) || (tcnt_q >= itr_q);
  assign rise_o = !irq_q && pending_i && ok_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (irq_q) irq_q <= pending_i;
    else            irq_q <= rise_o;
  end

  assign irq_o = irq_q;
  assign itr_o = itr_q;
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 18,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned ITR_W       = 16,
  parameter int unsigned TICK_CYCLES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               auto_mask_en_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  acc_e              acc;
  logic [DATA_W-1:0] cause_w, mask_w, amask_w, rd_mux, rdata_q;
  logic [ITR_W-1:0]  itr_w;
  logic              rd_w, wr_w, cause_acc, auto_w, pending_w, rise_w;

  always_comb begin
    acc = ACC_NONE;
    if      (addr_i == ADDR_W'(OFF_CAUSE)) acc = ACC_CAUSE;
    else if (addr_i == ADDR_W'(OFF_THROT)) acc = ACC_THROT;
    else if (addr_i == ADDR_W'(OFF_CSET))  acc = ACC_CSET;
    else if (addr_i == ADDR_W'(OFF_MSET))  acc = ACC_MSET;
    else if (addr_i == ADDR_W'(OFF_MCLR))  acc = ACC_MCLR;
    else if (addr_i == ADDR_W'(OFF_AMASK)) acc = ACC_AMASK;
  end

  assign rd_w      = req_i && !we_i;
  assign wr_w      = req_i && we_i;
  assign cause_acc = req_i && (acc == ACC_CAUSE);
  assign auto_w    = cause_acc && auto_mask_en_i && cause_w[DATA_W-1];
  assign pending_w = |(cause_w[CAUSE_W-1:0] & mask_w[CAUSE_W-1:0]);

  irq_cause_reg #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .set_i   (wr_w && (acc == ACC_CSET)),
    .rd_clr_i(rd_w && (acc == ACC_CAUSE)),
    .w1c_i   (wr_w && (acc == ACC_CAUSE)),
    .wdata_i (wdata_i),
    .assert_i(rise_w),
    .cause_o (cause_w)
  );

  irq_mask_reg u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_w && (acc == ACC_MSET)),
    .clr_i  (wr_w && (acc == ACC_MCLR)),
    .auto_i (auto_w),
    .am_wr_i(wr_w && (acc == ACC_AMASK)),
    .wdata_i(wdata_i),
    .mask_o (mask_w),
    .amask_o(amask_w)
  );

  irq_throttle #(.ITR_W(ITR_W), .TICK_CYCLES(TICK_CYCLES)) u_thr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .itr_wr_i   (wr_w && (acc == ACC_THROT)),
    .itr_wdata_i(wdata_i[ITR_W-1:0]),
    .pending_i  (pending_w),
    .irq_o      (irq_o),
    .rise_o     (rise_w),
    .itr_o      (itr_w)
  );

  always_comb begin
    case (acc)
      ACC_CAUSE:          rd_mux = cause_w;
      ACC_THROT:          rd_mux = DATA_W'(itr_w);
      ACC_MSET, ACC_MCLR: rd_mux = mask_w;
      ACC_AMASK:          rd_mux = amask_w;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_w) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 18,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned ITR_W       = 16,
  parameter int unsigned TICK_CYCLES = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               auto_mask_en_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               irq_o,
  input logic [DATA_W-1:0]  cause_i,
  input logic [DATA_W-1:0]  mask_i,
  input logic [DATA_W-1:0]  amask_i,
  input logic [ITR_W-1:0]   itr_i
);
  logic        prev_q;
  logic [31:0] gap_q;
  logic        pend;

  assign pend = |(cause_i[CAUSE_W-1:0] & mask_i[CAUSE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      gap_q  <= '1;
    end else begin
      prev_q <= irq_o;
      if (irq_o && !prev_q)  gap_q <= 32'd1;
      else if (gap_q != '1)  gap_q <= gap_q + 32'd1;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i[CAUSE_W-1:0] & ~CAUSE_IMPL) == '0); // R2

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFF_CAUSE) && evt_i == '0)
    |=> cause_i[CAUSE_W-1:0] == '0); // R3

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_MSET))
    |=> (mask_i & $past(wdata_i)) == $past(wdata_i)); // R5

  AST_RISE_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(pend)); // R6

  AST_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !pend) |=> !irq_o); // R6

  AST_FLAG_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> cause_i[DATA_W-1]); // R7

  AST_AUTO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == ADDR_W'(OFF_CAUSE) && auto_mask_en_i && cause_i[DATA_W-1])
    |=> (mask_i & $past(amask_i)) == '0); // R8

  AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !prev_q && itr_i != '0)
    |-> gap_q >= (32'(itr_i) * 32'(TICK_CYCLES) + 32'd1)); // R9
endmodule

bind irq_aggr irq_aggr_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ITR_W(ITR_W), .TICK_CYCLES(TICK_CYCLES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evt_i         (evt_i),
  .auto_mask_en_i(auto_mask_en_i),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .irq_o         (irq_o),
  .cause_i       (cause_w),
  .mask_i        (mask_w),
  .amask_i       (amask_w),
  .itr_i         (itr_w)
);

// File: tb/irq_aggr_bench.sv
module irq_aggr_bench;
  localparam int TICK = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] evt = '0;
  logic        am_en = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_aggr #(.TICK_CYCLES(TICK)) u_irq_aggr (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .auto_mask_en_i(am_en),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    req = 1'b0;
  endtask

  task automatic pulse(input logic [17:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    rd(16'hC0, d); check("R1 cause", d, 0);
    rd(16'hD0, d); check("R1 mask", d, 0);
    rd(16'hC4, d); check("R1 throttle", d, 0);
    rd(16'hE0, d); check("R1 automask", d, 0);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    pulse('1);
    rd(16'hC0, d); check("R2 implemented bits", d, 32'h0003_E6DF);
    rd(16'hC0, d); check("R3 cleared after read", d, 0);
  endtask

  task automatic t_read_keep;
    logic [31:0] d;
    evt = 18'h4;
    rd(16'hC0, d);
    evt = '0;
    check("R3 read with event", d, 0);
    rd(16'hC0, d); check("R3 event kept", d, 32'h4);
  endtask

  task automatic t_cause_set;
    logic [31:0] d;
    wr(16'hC8, 32'hFFFF_FFFF);
    rd(16'hC0, d); check("R4 cause set", d, 32'h0003_E6DF);
    rd(16'hC8, d); check("R10 cause set reads 0", d, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    pulse(18'h3);
    wr(16'hC0, 32'h1);
    rd(16'hC0, d); check("R11 write-one-clear", d, 32'h2);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(16'hD0, 32'h5);
    wr(16'hD0, 32'h2);
    rd(16'hD0, d); check("R5 mask set", d, 32'h7);
    wr(16'hD8, 32'h4);
    rd(16'hD8, d); check("R5 mask clear", d, 32'h3);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    pulse(18'h4);
    @(negedge clk);
    check("R6 masked cause no irq", 32'(irq), 0);
    pulse(18'h2);
    check("R6 irq not before latency", 32'(irq), 0);
    @(negedge clk);
    check("R6 irq rises", 32'(irq), 1);
    rd(16'hC0, d); check("R7 flag in cause", d, 32'h8000_0006);
    check("R6 irq holds until edge", 32'(irq), 1);
    @(negedge clk);
    check("R6 irq falls", 32'(irq), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(16'hC4, 32'hABCD_1234);
    rd(16'hC4, d); check("R10 throttle width", d, 32'h1234);
    wr(16'hE0, 32'h1234_5678);
    rd(16'hE0, d); check("R10 automask", d, 32'h1234_5678);
    rd(16'h0100, d); check("R10 unmapped", d, 0);
  endtask

  task automatic t_throttle;
    logic [31:0] d;
    int t0, t1;
    wr(16'hD8, 32'hFFFF_FFFF);
    wr(16'hD0, 32'h1);
    wr(16'hC4, 32'd2);
    rd(16'hC0, d);
    repeat (100) @(negedge clk);
    pulse(18'h1);
    @(negedge clk);
    check("R9 first rise free", 32'(irq), 1);
    t0 = cyc;
    rd(16'hC0, d);
    wr(16'hC8, 32'h1);
    for (int i = 0; i < 200; i++) begin
      if (irq) break;
      @(negedge clk);
    end
    t1 = cyc;
    check("R9 throttle spacing", 32'(t1 - t0), 32'(2 * TICK + 1));
    rd(16'hC0, d);
    wr(16'hC4, 32'd0);
    wr(16'hC8, 32'h1);
    check("R9 no throttle latency", 32'(irq), 0);
    @(negedge clk);
    check("R9 zero throttle immediate", 32'(irq), 1);
  endtask

  task automatic t_auto;
    logic [31:0] d;
    rd(16'hC0, d);
    wr(16'hE0, 32'h5);
    wr(16'hD0, 32'h7);
    am_en = 1'b1;
    rd(16'hC0, d);
    rd(16'hD0, d); check("R8 no flag no automask", d, 32'h7);
    pulse(18'h1);
    @(negedge clk);
    check("R8 irq before automask", 32'(irq), 1);
    wr(16'hC0, 32'h0);
    rd(16'hD8, d); check("R8 automask applied", d, 32'h2);
    check("R8 irq drops", 32'(irq), 0);
    am_en = 1'b0;
    wr(16'hD0, 32'h5);
    rd(16'hC0, d); check("R8 cause kept", d, 32'h8000_0001);
    rd(16'hD0, d); check("R8 disabled no automask", d, 32'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_read_keep();
    t_cause_set();
    t_w1c();
    t_mask();
    t_irq();
    t_regs();
    t_throttle();
    t_auto();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule